// File: doc/BRIEF.md
# Dual-Rate Serial Baud Generator

This block derives two independent rate strobes, one for a serial transmitter and one for a serial receiver, from the bus clock. It divides in two stages. The first stage is a shared prescaler with four selectable factors, two of which are not powers of two. The second stage is a pair of power-of-two dividers, one per direction. Each divider advances only when the prescaler strobes, so each direction runs at the prescaler factor times its own divisor.

All settings come from one packed 8-bit setting byte. Software writes it over a plain write strobe and reads it back on a parallel read bus. A write restarts every counter from zero, so the first strobe after a write arrives one full period after the write edge. The outputs are one-cycle tick pulses that the shift logic uses as clock enables. There is no data stream, so there is no valid/ready handshake. All pins are plain control and status.

Top module: `dual_rate_tick_gen`

## Requirements
- R1: After reset the setting byte reads 8'h00, and both tx_tick and rx_tick are high on every cycle until the first write (prescale 1, divisors 1).
- R2: rd_data shows exactly the byte last written, from the cycle after the write edge onward.
- R3: Setting bits [7:6] select the shared prescale factor P. Code 2'b00 gives 1, 2'b01 gives 3, 2'b10 gives 4 and 2'b11 gives 13.
- R4: Setting bits [5:3] hold code t. The transmit divisor is 2^t (1 to 128), and tx_tick repeats every P*2^t bus clocks.
- R5: Setting bits [2:0] hold code r. The receive divisor is 2^r (1 to 128), and rx_tick repeats every P*2^r bus clocks.
- R6: The transmit and receive periods are set independently. Different codes t and r give different tick periods at the same time.
- R7: A write restarts all counters. Counting the write edge as clock 0, the first tx_tick is sampled in clock P*2^t and the first rx_tick in clock P*2^r, whatever phase the old rates were in.
- R8: When the period of a path is greater than one clock, its tick is high for exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the setting byte |
| wr_data | input | 8 | Setting byte to write: {prescale[1:0], tx_code[2:0], rx_code[2:0]} |
| rd_data | output | 8 | Current setting byte |
| tx_tick | output | 1 | One-cycle transmit rate strobe |
| rx_tick | output | 1 | One-cycle receive rate strobe |

## Verification
The assertions assume that wr_en and wr_data are always known after reset and that a write is a strobe sampled at a clock edge. Some properties are qualified by the absence of a write in the same cycle, because a write may switch the rate to a factor of one in the middle of a period. The stimulus applies single-cycle writes from the falling edge and leaves the bus idle while it counts periods. This keeps every measured interval free of a restart, except for the deliberate mid-period rewrite that exercises the restart rule.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned PRE_CODE_W = 2;
  localparam int unsigned DIV_CODE_W = 3;
  localparam int unsigned PRE_LSB    = 6;
  localparam int unsigned TX_LSB     = 3;
  localparam int unsigned RX_LSB     = 0;
  localparam int unsigned N_PATHS    = 2;
  localparam int unsigned MAX_PRE    = 13;
  localparam int unsigned PRE_CNT_W  = $clog2(MAX_PRE);

  // terminal count of the prescaler for each factor code
  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_CODE_W-1:0] code);
    logic [PRE_CNT_W-1:0] lim;
    case (code)
      2'd0:    lim = PRE_CNT_W'(0);
      2'd1:    lim = PRE_CNT_W'(2);
      2'd2:    lim = PRE_CNT_W'(3);
      default: lim = PRE_CNT_W'(MAX_PRE - 1);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/bg_cfg_reg.sv
module bg_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             en
);
  logic [CNT_W-1:0] cnt;

  assign en = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bg_pow2_div.sv
module bg_pow2_div #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // 2^code - 1 as a mask of low ones
  always_comb limit = ~({CNT_W{1'b1}} << code);

  assign tick = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dual_rate_tick_gen.sv
module dual_rate_tick_gen
  import bg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             tx_tick,
  output logic             rx_tick
);
  logic [CFG_W-1:0]   cfg_q;
  logic               pre_en;
  logic [N_PATHS-1:0] ticks;

  bg_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(cfg_q)
  );

  bg_prescaler #(.CNT_W(PRE_CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_en),
    .limit(pre_limit(cfg_q[PRE_LSB +: PRE_CODE_W])),
    .en(pre_en)
  );

  // path 0 = transmit, path 1 = receive
  for (genvar g = 0; g < N_PATHS; g++) begin : g_path
    localparam int unsigned LSB = (g == 0) ? TX_LSB : RX_LSB;
    bg_pow2_div #(.CODE_W(DIV_CODE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(wr_en), .step(pre_en),
      .code(cfg_q[LSB +: DIV_CODE_W]),
      .tick(ticks[g])
    );
  end

  assign rd_data = cfg_q;
  assign tx_tick = ticks[0];
  assign rx_tick = ticks[1];
endmodule

// File: rtl/bg_checker.sv
module bg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [7:0] cfg,
  input logic       pre_en,
  input logic       tx_tick,
  input logic       rx_tick
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R3
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !wr_en && cfg[7:6] != 2'b00) |=> !pre_en);

  // R4
  tx_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> pre_en);

  // R5
  rx_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |-> pre_en);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:6] != 2'b00) |=> (!tx_tick && !rx_tick));

  // R8
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && !wr_en && cfg[5:3] != 3'd0) |=> !tx_tick);

  // R8
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && !wr_en && cfg[2:0] != 3'd0) |=> !rx_tick);
endmodule

bind dual_rate_tick_gen bg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .cfg(cfg_q), .pre_en(pre_en),
  .tx_tick(tx_tick), .rx_tick(rx_tick)
);

// File: tb/dual_rate_tick_gen_tb.sv
module dual_rate_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tx_tick, rx_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_rate_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  // {setting byte, expected tx period, expected rx period}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 16'd1,    16'd1},
    {8'h47, 16'd3,    16'd384},
    {8'hB8, 16'd512,  16'd4},
    {8'hD5, 16'd52,   16'd416},
    {8'hFF, 16'd1664, 16'd1664},
    {8'h1E, 16'd8,    16'd64},
    {8'h69, 16'd96,   16'd6},
    {8'hA2, 16'd64,   16'd16}
  };

  function automatic int pre_factor(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input logic [7:0] cfg, input int etx, input int erx);
    int n = 0;
    int tx1 = -1, tx2 = -1, rx1 = -1, rx2 = -1;
    int tx_after = -1, rx_after = -1;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = cfg;
    @(posedge clk);
    #1 wr_en = 1'b0;
    while ((tx2 < 0 || rx2 < 0) && n < 5000) begin
      @(negedge clk);
      n++;
      if (n == 1) check(rd_data == cfg, "R2 readback", int'(rd_data), int'(cfg));
      if (tx1 > 0 && n == tx1 + 1) tx_after = int'(tx_tick);
      if (rx1 > 0 && n == rx1 + 1) rx_after = int'(rx_tick);
      if (tx_tick) begin
        if (tx1 < 0) tx1 = n;
        else if (tx2 < 0) tx2 = n;
      end
      if (rx_tick) begin
        if (rx1 < 0) rx1 = n;
        else if (rx2 < 0) rx2 = n;
      end
    end
    check(tx1 == etx, "R7 tx first tick", tx1, etx);
    check(rx1 == erx, "R7 rx first tick", rx1, erx);
    check(tx2 - tx1 == etx, "R4/R3 tx period", tx2 - tx1, etx);
    check(rx2 - rx1 == erx, "R5/R3 rx period", rx2 - rx1, erx);
    if (etx > 1) check(tx_after == 0, "R8 tx width", tx_after, 0);
    if (erx > 1) check(rx_after == 0, "R8 rx width", rx_after, 0);
    if (etx != erx) check((tx2 - tx1) != (rx2 - rx1), "R6 independent", tx2 - tx1, etx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_data == 8'h00, "R1 reset value", int'(rd_data), 0);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tx_tick && rx_tick, "R1 ticks every cycle", int'({tx_tick, rx_tick}), 3);
    end

    for (int v = 0; v < NV; v++)
      run_cfg(VEC[v][39:32], int'(VEC[v][31:16]), int'(VEC[v][15:0]));

    // full sweep: every prescaler code with every divisor code
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] cfg;
        cfg = {2'(p), 3'(c), 3'(7 - c)};
        run_cfg(cfg, pre_factor(p) * (1 << c), pre_factor(p) * (1 << (7 - c)));
      end
    end

    // R7: rewrite in the middle of a running period
    run_cfg(8'hD5, 52, 416);
    repeat (30) @(negedge clk);
    run_cfg(8'hD5, 52, 416);
    repeat (7) @(negedge clk);
    run_cfg(8'h47, 3, 384);

    // R1: reset again returns to the reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(rd_data == 8'h00, "R1 reset after use", int'(rd_data), 0);
    @(negedge clk);
    check(tx_tick && rx_tick, "R1 ticks after reset", int'({tx_tick, rx_tick}), 3);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule